// File: doc/BRIEF.md
# Big-endian load/store lane unit

This block sits between a processor's load/store pipeline and a data memory that is one 32-bit word wide. The processor hands it one access at a time. Each access carries a byte address, an access size, a direction, store data and a choice between signed and unsigned loads. The block turns the byte address into a word index and a 4-bit lane mask. On stores it moves the store data into the addressed lanes. On loads it takes the returned word, picks out the addressed lanes and widens them to 32 bits.

Lanes follow big-endian order: the lowest byte address within a word maps to the most significant byte. An access that is not aligned to its own size is never split into several memory operations. Instead it is refused. The memory strobe stays low and a one-cycle fault pulse is raised in the cycle where the strobe would have appeared. A request handshake keeps at most one access in flight at a time.

Top module: `be_lsu`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `fault` and `rsp_valid` are 0.
- R2: In the cycle after a request is accepted, an aligned access raises `mem_req` for exactly one cycle, with `mem_addr` equal to the byte address bits [31:2] and `mem_we` equal to the request's write flag.
- R3: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. With the address offset k = addr[1:0], the lane mask `mem_be` (bit 3 covers data bits [31:24]) is 1 shifted left by (3-k) for a byte, 1100 for a halfword at offset 00, 0011 for a halfword at offset 10, and 1111 for a word.
- R4: For a store, every enabled lane of `mem_wdata` holds the matching part of the store data: the low byte of `req_wdata` for a byte access, `req_wdata[15:0]` for a halfword with the upper byte in the lower-addressed lane, and all of `req_wdata` for a word.
- R5: An unsigned load returns the addressed lane(s) of `mem_rdata` shifted down to bit 0 and zero-filled above. Offset 00 selects bits [31:24], offset 11 selects bits [7:0], and a halfword at offset 00 selects bits [31:16].
- R6: When `req_signed` is 1, a byte or halfword load copies the top bit of the extracted value into every higher bit of `rsp_rdata`.
- R7: The following accesses are faults: a halfword with address bit 0 set, a word with address bits [1:0] not equal to 00, and any access with size code 11. For a fault, `fault` is high for exactly the one cycle after acceptance, `mem_req` stays low, and no `rsp_valid` follows.
- R8: `req_ready` is low from the cycle after an acceptance until the access completes, so only one access is outstanding.
- R9: The memory answers no earlier than the cycle after `mem_req`. `rsp_valid` pulses for one cycle on the cycle after `mem_rvalid` is sampled, for loads and stores alike. `req_ready` returns high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_write | input | 1 | 1 store, 0 load |
| req_signed | input | 1 | Sign-extend load result |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_req | output | 1 | One-cycle memory strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Word index |
| mem_be | output | 4 | Lane mask, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rvalid | input | 1 | Memory response |
| mem_rdata | input | 32 | Memory read word |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | 32 | Extended load result, 0 for stores |
| fault | output | 1 | Misalignment pulse |

## Verification
The properties assume that `mem_rvalid` is raised only while an access is waiting, never in the strobe cycle itself and never while the unit is idle. They also assume that request fields are meaningful only in the cycle they are accepted. The bench drives the memory side as a well-behaved single-response model: it raises `mem_rvalid` for one cycle, one or more cycles after the strobe, and only for aligned accesses. It changes request fields only on falling edges, and only while it holds `req_valid` for a single accepted cycle.

// File: rtl/be_lsu.sv
module be_lsu #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_signed,
  input  logic [31:0]       req_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              fault
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FAULT} st_t;

  st_t        st;
  logic [1:0] off_q, size_q;
  logic       sgn_q;
  logic       misal;
  logic [3:0] be_n;
  logic [31:0] wd_n;
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic [31:0] ext;

  wire        accept = req_valid && req_ready;
  wire [1:0]  off    = req_addr[1:0];

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_ISSUE);
  assign fault     = (st == S_FAULT);

  always_comb begin
    case (req_size)
      2'b00:   misal = 1'b0;
      2'b01:   misal = off[0];
      2'b10:   misal = |off;
      default: misal = 1'b1;
    endcase
  end

  always_comb begin
    case (req_size)
      2'b00: begin
        be_n = 4'b1000 >> off;
        wd_n = {4{req_wdata[7:0]}};
      end
      2'b01: begin
        be_n = off[1] ? 4'b0011 : 4'b1100;
        wd_n = {2{req_wdata[15:0]}};
      end
      default: begin
        be_n = 4'b1111;
        wd_n = req_wdata;
      end
    endcase
  end

  always_comb begin
    case (off_q)
      2'b00:   byte_sel = mem_rdata[31:24];
      2'b01:   byte_sel = mem_rdata[23:16];
      2'b10:   byte_sel = mem_rdata[15:8];
      default: byte_sel = mem_rdata[7:0];
    endcase
    half_sel = off_q[1] ? mem_rdata[15:0] : mem_rdata[31:16];
    case (size_q)
      2'b00:   ext = {{24{sgn_q & byte_sel[7]}}, byte_sel};
      2'b01:   ext = {{16{sgn_q & half_sel[15]}}, half_sel};
      default: ext = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      off_q     <= '0;
      size_q    <= '0;
      sgn_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st        <= misal ? S_FAULT : S_ISSUE;
          mem_we    <= req_write;
          mem_addr  <= req_addr[ADDR_W-1:2];
          mem_be    <= misal ? 4'b0000 : be_n;
          mem_wdata <= wd_n;
          off_q     <= off;
          size_q    <= req_size;
          sgn_q     <= req_signed;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_we ? 32'h0 : ext;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module be_lsu_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              mem_req,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              mem_rvalid,
  input logic              rsp_valid,
  input logic              fault
);

  wire acc = req_valid && req_ready;

  assert_word_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (mem_addr == $past(req_addr[ADDR_W-1:2])));

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_size == 2'b00) |=> (mem_req && $countones(mem_be) == 1));

  assert_word_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_size == 2'b10 && req_addr[1:0] == 2'b00) |=> (mem_req && mem_be == 4'hF));

  assert_half_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_size == 2'b01 && req_addr[0]) |=> (fault && !mem_req));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault, mem_req, rsp_valid}));

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  assert_rsp_after_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_rvalid) && !$past(req_ready)));

endmodule

bind be_lsu be_lsu_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_rvalid(mem_rvalid),
  .rsp_valid(rsp_valid), .fault(fault)
);

// File: tb/be_lsu_test.sv
module be_lsu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_signed = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        fault;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  be_lsu uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_signed(req_signed), .req_wdata(req_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .fault(fault)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [1:0]  off;
    logic        sg;
    logic        flt;
    logic [3:0]  be;
    logic [31:0] wexp;
    logic [31:0] rexp;
  } vec_t;

  localparam logic [31:0] BASE  = 32'h1000_0040;
  localparam logic [31:0] WDATA = 32'h1234_56F7;
  localparam logic [31:0] MWORD = 32'h8A7B_C5D6;
  localparam int NV = 20;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 4'b1000, 32'hF700_0000, 32'h0},
    '{1'b1, 2'b00, 2'b01, 1'b0, 1'b0, 4'b0100, 32'h00F7_0000, 32'h0},
    '{1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 4'b0010, 32'h0000_F700, 32'h0},
    '{1'b1, 2'b00, 2'b11, 1'b0, 1'b0, 4'b0001, 32'h0000_00F7, 32'h0},
    '{1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 4'b1100, 32'h56F7_0000, 32'h0},
    '{1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 4'b0011, 32'h0000_56F7, 32'h0},
    '{1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 4'b1111, 32'h1234_56F7, 32'h0},
    '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'b1000, 32'h0, 32'h0000_008A},
    '{1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 4'b1000, 32'h0, 32'hFFFF_FF8A},
    '{1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 4'b0100, 32'h0, 32'h0000_007B},
    '{1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 4'b0010, 32'h0, 32'hFFFF_FFC5},
    '{1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 4'b0001, 32'h0, 32'h0000_00D6},
    '{1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 4'b1100, 32'h0, 32'hFFFF_8A7B},
    '{1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 4'b0011, 32'h0, 32'h0000_C5D6},
    '{1'b0, 2'b01, 2'b10, 1'b1, 1'b0, 4'b0011, 32'h0, 32'hFFFF_C5D6},
    '{1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 4'b1111, 32'h0, 32'h8A7B_C5D6},
    '{1'b0, 2'b01, 2'b01, 1'b0, 1'b1, 4'b0000, 32'h0, 32'h0},
    '{1'b0, 2'b10, 2'b10, 1'b0, 1'b1, 4'b0000, 32'h0, 32'h0},
    '{1'b1, 2'b10, 2'b11, 1'b0, 1'b1, 4'b0000, 32'h0, 32'h0},
    '{1'b1, 2'b11, 2'b00, 1'b0, 1'b1, 4'b0000, 32'h0, 32'h0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic run(vec_t v, logic [31:0] addr, int dly);
    @(negedge clk);
    chk("R8 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = addr; req_size = v.sz; req_write = v.wr;
    req_signed = v.sg; req_wdata = WDATA;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ready low after accept", 32'(req_ready), 32'd0);
    if (v.flt) begin
      chk("R7 fault pulse", 32'(fault), 32'd1);
      chk("R7 no strobe on fault", 32'(mem_req), 32'd0);
      @(negedge clk);
      chk("R7 fault one cycle", 32'(fault), 32'd0);
      chk("R7 no response on fault", 32'(rsp_valid), 32'd0);
      chk("R7 ready after fault", 32'(req_ready), 32'd1);
    end else begin
      chk("R2 strobe", 32'(mem_req), 32'd1);
      chk("R2 word index", 32'(mem_addr), addr >> 2);
      chk("R2 write flag", 32'(mem_we), 32'(v.wr));
      chk("R3 lane mask", 32'(mem_be), 32'(v.be));
      if (v.wr) chk("R4 store lanes", mem_wdata & lanes(v.be), v.wexp);
      @(negedge clk);
      chk("R2 strobe one cycle", 32'(mem_req), 32'd0);
      for (int i = 0; i < dly; i++) begin
        chk("R8 busy while waiting", 32'(req_ready), 32'd0);
        chk("R9 no early response", 32'(rsp_valid), 32'd0);
        @(negedge clk);
      end
      mem_rvalid = 1'b1; mem_rdata = MWORD;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'h0;
      chk("R9 response pulse", 32'(rsp_valid), 32'd1);
      chk("R9 ready with response", 32'(req_ready), 32'd1);
      chk(v.sg ? "R6 load signed" : "R5 load data", rsp_rdata, v.rexp);
      @(negedge clk);
      chk("R9 response one cycle", 32'(rsp_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 fault", 32'(fault), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run(VEC[i], BASE | 32'(VEC[i].off), i % 3);

    run('{1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 4'b1111, 32'h0, 32'h8A7B_C5D6}, 32'hFFFF_FFFC, 0);
    run('{1'b0, 2'b00, 2'b11, 1'b1, 1'b0, 4'b0001, 32'h0, 32'hFFFF_FFD6}, 32'h0000_0003, 5);
    run('{1'b0, 2'b10, 2'b01, 1'b0, 1'b1, 4'b0000, 32'h0, 32'h0}, 32'h0000_0001, 0);
    run('{1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 4'b0011, 32'h0000_56F7, 32'h0}, 32'h0000_0012, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule